// File: doc/BRIEF.md
# Byte-Lane SRAM with Single-Error Correction

This block is a clocked model of a word-organised static memory that guards each stored 16-bit word with a SEC-DED code. A write needs an active-low chip select and an active-low write strobe. Two active-low lane enables choose which bytes of the addressed word change. A lane write that covers only one byte reads the old codeword inside the block, corrects it, merges in the new byte, re-encodes the word and stores it whole. A read needs the chip select and the active-low output enable, with the write strobe high. The corrected data appears one clock later on the output half of a split bidirectional bus. Each byte lane has its own drive-enable bit.

A read that finds and repairs one flipped bit raises a flag for that output cycle. The repaired value is never written back, so the fault stays in the array until the word is written again. A word with two flipped bits is reported on a separate status output, and its uncorrected data bits are passed through. A fault-injection port can invert any single stored codeword bit at any address, so the correction path can be reached from the ports.

The address input is 18 bits wide. The number of words actually held is set by a parameter, and its default is kept small.

Top module: `secded_sram`

## Requirements
- R1: After reset, neither lane is driven, both flags are low, and every word reads back as 0x0000.
- R2: At a rising edge where the chip select and the write strobe are both low, and at least one lane enable is low, the block stores the bus input at the addressed word. A later full read returns that value.
- R3: The upper lane enable governs data bits 15..8 and the lower lane enable governs bits 7..0. A write changes only the enabled bytes, and the other byte keeps its earlier value. With both lane enables high, a write changes nothing.
- R4: A read is sampled at a rising edge where the chip select and the output enable are low, the write strobe is high, and at least one lane enable is low. In the following cycle the data appears on `dq_o`. `dq_oe_o[1]` is high only if the upper lane was enabled, and `dq_oe_o[0]` is high only if the lower lane was enabled.
- R5: In the cycle after an edge where the chip select is high, or the output enable is high, or both lane enables are high, `dq_oe_o` is 2'b00 and the flags are low.
- R6: When the write strobe and the output enable are both low with the chip select low, the write is performed and no lane is driven in the next cycle.
- R7: The codeword has 22 bits, numbered by position p from 0 to 21. Position 0 is the overall parity bit. Positions 1, 2, 4, 8 and 16 are check bits. The remaining positions hold data bits 0 to 15 in increasing order, so data bit 0 is at 3, data bit 1 at 5, and data bit 15 at 21. If the stored word has any one position flipped, a read returns the original data with `err_o` high and `uncorr_o` low.
- R8: A corrected read does not repair the array, so a second read of the same word raises `err_o` again.
- R9: With two positions flipped, a read keeps `err_o` low and raises `uncorr_o`. The returned data is the stored data bits without correction.
- R10: A single-lane write to a word that holds one flipped bit merges the new byte with the corrected old byte. A later read returns the merged value with both flags low.
- R11: Only the low `MEM_AW` address bits select a word (default 10, which gives 1024 words). Addresses that differ only above those bits reach the same word.
- R12: When `inj_en_i` is high at a rising edge, stored position `inj_bit_i` of word `inj_addr_i` is inverted. A position value of 22 or more leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, clears the array and the outputs |
| ce_n_i | input | 1 | Active-low chip select |
| we_n_i | input | 1 | Active-low write strobe |
| oe_n_i | input | 1 | Active-low output enable |
| ub_n_i | input | 1 | Active-low upper lane enable (bits 15..8) |
| lb_n_i | input | 1 | Active-low lower lane enable (bits 7..0) |
| addr_i | input | 18 | Word address |
| dq_i | input | 16 | Bus data into the block |
| dq_o | output | 16 | Bus data out of the block |
| dq_oe_o | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| err_o | output | 1 | A single-bit error was corrected on this read |
| uncorr_o | output | 1 | Test status: this read found an uncorrectable word |
| inj_en_i | input | 1 | Test: invert one stored bit at this edge |
| inj_addr_i | input | 18 | Test: word to corrupt |
| inj_bit_i | input | 5 | Test: codeword position to invert (0..21) |

## Verification
Corrupted storage cannot be produced through the normal bus, because every write stores a clean codeword. The bench therefore uses the injection port to flip chosen positions in a word it has just written. It sweeps all 22 positions for single faults, flips pairs of check bits and pairs of data bits for double faults, and then reads the word twice to show that the fault persists. The hardest case is a lane write on top of a corrupted word. Here the bench injects a data-bit fault into the byte that is *not* being written. Only a merge that uses the corrected old value then gives the expected result.

// File: rtl/secded_sram_pkg.sv
package secded_sram_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int CHK_W  = 5;
    localparam int CODE_W = DATA_W + CHK_W + 1;
    localparam int POS_W  = $clog2(CODE_W);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        data_t            dout;
        logic [LANES-1:0] lane;
        logic             err;
        logic             unc;
    } out_regs_t;

    function automatic logic is_chk_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic code_t place_data(data_t d);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_chk_pos(p) && k < DATA_W) begin
                c[p] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    function automatic data_t pick_data(code_t c);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_chk_pos(p) && k < DATA_W) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [CHK_W-1:0] syndrome_of(code_t c);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (c[p]) s = s ^ CHK_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_sram_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    code_t body;
    logic [CHK_W-1:0] chk;

    always_comb begin
        body   = place_data(data_i);
        chk    = syndrome_of(body);
        code_o = body;
        for (int i = 0; i < CHK_W; i++) begin
            code_o[1 << i] = chk[i];
        end
        code_o[0] = ^code_o[CODE_W-1:1];
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_sram_pkg::*;
(
    input  code_t code_i,
    output data_t data_o,
    output logic  single_o,
    output logic  double_o
);
    logic [CHK_W-1:0] syn;
    logic             par;
    code_t            fixed;

    always_comb begin
        syn      = syndrome_of(code_i);
        par      = ^code_i;
        single_o = par && (int'(syn) < CODE_W);
        double_o = (!par && syn != '0) || (par && int'(syn) >= CODE_W);
        fixed    = code_i;
        if (single_o) fixed[POS_W'(syn)] = ~code_i[POS_W'(syn)];
        data_o   = pick_data(fixed);
    end

    // one word cannot be both repaired and uncorrectable (R9)
    always_comb begin
        p_kind_exclusive_r9: assert (!(single_o && double_o));
    end

endmodule

// File: rtl/secded_store.sv
module secded_store
    import secded_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  code_t         wr_word_i,
    input  logic [AW-1:0] rd_addr_i,
    output code_t         rd_word_o,
    input  logic          flip_en_i,
    input  logic [AW-1:0] flip_addr_i,
    input  logic [POS_W-1:0] flip_pos_i
);
    localparam int DEPTH = 1 << AW;

    code_t mem_d [DEPTH];
    code_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en_i) mem_d[wr_addr_i] = wr_word_i;
        if (flip_en_i && int'(flip_pos_i) < CODE_W) begin
            mem_d[flip_addr_i][flip_pos_i] = ~mem_d[flip_addr_i][flip_pos_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word_o = mem_q[rd_addr_i];

    // reads never write back: without a write or a flip, a held address keeps its word (R8)
    p_no_scrub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !flip_en_i) |=> ($stable(rd_addr_i) -> $stable(rd_word_o)));

endmodule

// File: rtl/secded_sram.sv
module secded_sram
    import secded_sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              ub_n_i,
    input  logic              lb_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic [1:0]        dq_oe_o,
    output logic              err_o,
    output logic              uncorr_o,
    input  logic              inj_en_i,
    input  logic [ADDR_W-1:0] inj_addr_i,
    input  logic [4:0]        inj_bit_i
);
    code_t            old_word;
    code_t            new_word;
    data_t            old_data;
    data_t            merged;
    logic             old_single;
    logic             old_double;
    logic [LANES-1:0] lane_en;
    logic             wr_go;
    logic             rd_go;
    out_regs_t        out_d;
    out_regs_t        out_q;

    secded_store #(.AW(MEM_AW)) i_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_go),
        .wr_addr_i   (addr_i[MEM_AW-1:0]),
        .wr_word_i   (new_word),
        .rd_addr_i   (addr_i[MEM_AW-1:0]),
        .rd_word_o   (old_word),
        .flip_en_i   (inj_en_i),
        .flip_addr_i (inj_addr_i[MEM_AW-1:0]),
        .flip_pos_i  (inj_bit_i[POS_W-1:0])
    );

    secded_dec i_dec (
        .code_i   (old_word),
        .data_o   (old_data),
        .single_o (old_single),
        .double_o (old_double)
    );

    secded_enc i_enc (
        .data_i (merged),
        .code_o (new_word)
    );

    always_comb begin
        lane_en = {~ub_n_i, ~lb_n_i};
        wr_go   = !ce_n_i && !we_n_i && (|lane_en);
        rd_go   = !ce_n_i && !oe_n_i && we_n_i && (|lane_en);

        for (int b = 0; b < LANES; b++) begin
            merged[b*8 +: 8] = lane_en[b] ? dq_i[b*8 +: 8] : old_data[b*8 +: 8];
        end

        out_d = '0;
        if (rd_go) begin
            for (int b = 0; b < LANES; b++) begin
                out_d.dout[b*8 +: 8] = lane_en[b] ? old_data[b*8 +: 8] : 8'h00;
            end
            out_d.lane = lane_en;
            out_d.err  = old_single;
            out_d.unc  = old_double;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign dq_o     = out_q.dout;
    assign dq_oe_o  = out_q.lane;
    assign err_o    = out_q.err;
    assign uncorr_o = out_q.unc;

    // deselect or output disable leaves the bus undriven next cycle (R5)
    p_hiz_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_n_i || oe_n_i) |=> (dq_oe_o == 2'b00 && !err_o && !uncorr_o));

    // a write, even with output enable low, never drives the bus (R6)
    p_write_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_n_i && !we_n_i) |=> (dq_oe_o == 2'b00));

    // a driven lane must have been enabled at the read edge (R4)
    p_lane_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ub_n_i && lb_n_i) |=> (dq_oe_o == 2'b00));

    // the flags only accompany driven read data (R7)
    p_flag_with_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o || uncorr_o) |-> (dq_oe_o != 2'b00));

endmodule

// File: tb/test_secded_sram.sv
module test_secded_sram;

    localparam int MEM_AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [17:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        err, uncorr;
    logic        inj_en = 1'b0;
    logic [17:0] inj_addr = '0;
    logic [4:0]  inj_bit = '0;

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    secded_sram #(.ADDR_W(18), .MEM_AW(MEM_AW)) i_secded_sram (
        .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .ub_n_i(ub_n), .lb_n_i(lb_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
        .dq_oe_o(dq_oe), .err_o(err), .uncorr_o(uncorr), .inj_en_i(inj_en),
        .inj_addr_i(inj_addr), .inj_bit_i(inj_bit)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; inj_en = 1'b0;
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic [1:0] lanes_n);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; {ub_n, lb_n} = lanes_n; addr = a; dq_in = d;
        @(negedge clk);
        go_idle();
    endtask

    task automatic inject(input logic [17:0] a, input int pos);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_bit = 5'(pos);
        @(negedge clk);
        go_idle();
    endtask

    // issue a read, sample the registered outputs one cycle later
    task automatic rd(input logic [17:0] a, input logic [1:0] lanes_n,
                      output logic [15:0] d, output logic [1:0] oe, output logic e, output logic u);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; {ub_n, lb_n} = lanes_n; addr = a;
        @(negedge clk);
        d = dq_out; oe = dq_oe; e = err; u = uncorr;
        go_idle();
    endtask

    task automatic rd_expect(input string req, input logic [17:0] a, input logic [15:0] exp_d,
                             input logic exp_e, input logic exp_u);
        logic [15:0] d; logic [1:0] oe; logic e, u;
        rd(a, 2'b00, d, oe, e, u);
        chk(d == exp_d, req, 32'(d), 32'(exp_d));
        chk(oe == 2'b11 && e == exp_e && u == exp_u, req, {29'd0, oe, e} ^ 32'(u) << 8,
            {29'd0, 2'b11, exp_e} ^ 32'(exp_u) << 8);
    endtask

    task automatic t_reset();
        chk(dq_oe == 2'b00 && !err && !uncorr, "R1", {29'd0, dq_oe, err}, 0);
        rd_expect("R1", 18'd5, 16'h0000, 1'b0, 1'b0);
        rd_expect("R1", 18'd1000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_write_read();
        wr(18'd1, 16'hBEEF, 2'b00);
        wr(18'd2, 16'h0001, 2'b00);
        wr(18'd3, 16'hFFFF, 2'b00);
        rd_expect("R2", 18'd1, 16'hBEEF, 1'b0, 1'b0);
        rd_expect("R2", 18'd2, 16'h0001, 1'b0, 1'b0);
        rd_expect("R2", 18'd3, 16'hFFFF, 1'b0, 1'b0);
    endtask

    task automatic t_lanes();
        logic [15:0] d; logic [1:0] oe; logic e, u;
        wr(18'd10, 16'h1234, 2'b00);
        wr(18'd10, 16'hAB99, 2'b01);
        rd_expect("R3", 18'd10, 16'hAB34, 1'b0, 1'b0);
        wr(18'd10, 16'h77CD, 2'b10);
        rd_expect("R3", 18'd10, 16'hABCD, 1'b0, 1'b0);
        wr(18'd10, 16'h0000, 2'b11);
        rd_expect("R3", 18'd10, 16'hABCD, 1'b0, 1'b0);
        rd(18'd10, 2'b01, d, oe, e, u);
        chk(oe == 2'b10 && d[15:8] == 8'hAB, "R4", {14'd0, oe, d}, {14'd0, 2'b10, 16'hAB00});
        rd(18'd10, 2'b10, d, oe, e, u);
        chk(oe == 2'b01 && d[7:0] == 8'hCD, "R4", {14'd0, oe, d}, {14'd0, 2'b01, 16'h00CD});
    endtask

    task automatic t_hiz();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0; addr = 18'd10;
        @(negedge clk);
        chk(dq_oe == 2'b00, "R5", 32'(dq_oe), 0);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 2'b00, "R5", 32'(dq_oe), 0);
        oe_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 2'b00 && !err, "R5", 32'(dq_oe), 0);
        go_idle();
    endtask

    task automatic t_write_priority();
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; addr = 18'd20; dq_in = 16'h5A5A;
        @(negedge clk);
        chk(dq_oe == 2'b00, "R6", 32'(dq_oe), 0);
        go_idle();
        rd_expect("R6", 18'd20, 16'h5A5A, 1'b0, 1'b0);
    endtask

    task automatic t_single_sweep();
        for (int p = 0; p < 22; p++) begin
            wr(18'(100 + p), 16'hA5C3, 2'b00);
            inject(18'(100 + p), p);
            rd_expect("R7", 18'(100 + p), 16'hA5C3, 1'b1, 1'b0);
        end
        @(negedge clk);
        chk(!err, "R7", 32'(err), 0);
        rd_expect("R8", 18'd105, 16'hA5C3, 1'b1, 1'b0);
        rd_expect("R8", 18'd105, 16'hA5C3, 1'b1, 1'b0);
    endtask

    task automatic t_double();
        wr(18'd200, 16'h3C3C, 2'b00);
        inject(18'd200, 1);
        inject(18'd200, 2);
        rd_expect("R9", 18'd200, 16'h3C3C, 1'b0, 1'b1);
        wr(18'd201, 16'h3C3C, 2'b00);
        inject(18'd201, 3);
        inject(18'd201, 5);
        rd_expect("R9", 18'd201, 16'h3C3F, 1'b0, 1'b1);
    endtask

    task automatic t_merge_fault();
        wr(18'd300, 16'h1234, 2'b00);
        inject(18'd300, 3);
        wr(18'd300, 16'hAB00, 2'b01);
        rd_expect("R10", 18'd300, 16'hAB34, 1'b0, 1'b0);
    endtask

    task automatic t_alias();
        wr(18'd7, 16'h0F0F, 2'b00);
        rd_expect("R11", 18'd7 + 18'(1 << MEM_AW), 16'h0F0F, 1'b0, 1'b0);
        wr(18'd7 + 18'(3 << MEM_AW), 16'hF00D, 2'b00);
        rd_expect("R11", 18'd7, 16'hF00D, 1'b0, 1'b0);
    endtask

    task automatic t_inject_range();
        wr(18'd400, 16'h6789, 2'b00);
        inject(18'd400, 22);
        inject(18'd400, 31);
        rd_expect("R12", 18'd400, 16'h6789, 1'b0, 1'b0);
        inject(18'd400, 21);
        rd_expect("R12", 18'd400, 16'h6789, 1'b1, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_lanes();
        t_hiz();
        t_write_priority();
        t_single_sweep();
        t_double();
        t_merge_fault();
        t_alias();
        t_inject_range();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule